// File: doc/BRIEF.md
# Interrupt Status and Mask Unit

This block is the interrupt register set of a card host controller. The command and data engines report events as one-cycle pulses on a 32-bit event bus. Each pulse whose status-enable bit is set is latched in a status register, where it stays until software clears it by writing 1 to it. A second mask, the signal-enable register, selects which latched bits may raise the single level-sensitive interrupt request.

A force register lets test software set any implemented status bit directly, without any engine activity. Bit 15 of the status view is not stored. It is a read-only summary that reads 1 while any error bit is set. All four registers share one simple word-addressed read/write port. Read data is combinational from the register state.

Top module: `irq_status_regs`

## Requirements
- R1: After reset, the status, status-enable and signal-enable registers read 0 and `irq_o` is 0.
- R2: An event pulse on an implemented bit whose status-enable bit is 1 sets that status bit at the next clock edge. The implemented event bits are 0 (command done), 1 (data done), 4 (write ready), 5 (read ready), 6 (card insert), 8 (card interrupt), 16 (command timeout), 17 (command CRC), 18 (command end bit), 19 (command index), 20 (data timeout), 21 (data CRC), 22 (data end bit) and 24 (auto-command error).
- R3: An event pulse whose status-enable bit is 0 is not latched. Status bits that are not implemented always read 0.
- R4: Status bit 15 reads 1 exactly when at least one of the status bits from 16 upward is set. Bit 15 cannot be written, forced or cleared.
- R5: Writing to address 0 (status) clears each status bit written as 1. Bits written as 0 keep their value.
- R6: Writing to address 3 (force) sets every implemented status bit written as 1, whatever the status-enable mask holds. Address 3 reads back 0.
- R7: When an enabled event and a write-1-to-clear hit the same bit in the same cycle, the bit stays set.
- R8: `irq_o` is the OR over all bits of (status view AND signal-enable), registered. It follows a change of status or signal-enable one clock edge later.
- R9: Address 1 reads back the status-enable mask, limited to the implemented event bits. Address 2 reads back the signal-enable mask, limited to the implemented event bits plus bit 15.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| evt_i | input | 32 | Event pulses from the command and data engines, one bit per event |
| wr_i | input | 1 | Register write strobe |
| addr_i | input | 2 | Word address: 0 status, 1 status-enable, 2 signal-enable, 3 force |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for `addr_i` |
| irq_o | output | 1 | Registered interrupt request, active high |

## Verification
The embedded assertions check the cycle-level rules on every clock: an enabled event always lands in the next cycle, no bit appears without an enable or a force, an idle cycle leaves the status untouched, a clear removes the written bits, and an empty signal-enable mask keeps the interrupt low. The bench's sweeps over every bit position are the only check on the bit map itself. They cover which positions are implemented, the error summary and its routing to the interrupt, the read-back masking of both enable registers and the force register, and the exact cycle in which the interrupt follows a status change.

// File: rtl/irq_status_regs.sv
module irq_status_regs (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [31:0] evt_i,
  input  logic        wr_i,
  input  logic [1:0]  addr_i,
  input  logic [31:0] wdata_i,
  output logic [31:0] rdata_o,
  output logic        irq_o
);

  localparam logic [31:0] NORM_BITS = 32'h0000_0173;
  localparam logic [31:0] ERR_BITS  = 32'h017F_0000;
  localparam logic [31:0] EVT_BITS  = NORM_BITS | ERR_BITS;
  localparam int          SUM_POS   = 15;
  localparam logic [31:0] SIG_BITS  = EVT_BITS | (32'd1 << SUM_POS);

  localparam logic [1:0] A_STAT  = 2'd0;
  localparam logic [1:0] A_SEN   = 2'd1;
  localparam logic [1:0] A_IEN   = 2'd2;
  localparam logic [1:0] A_FORCE = 2'd3;

  logic [31:0] stat_q, sen_q, ien_q;
  logic        irq_q;

  wire         wr_stat  = wr_i && addr_i == A_STAT;
  wire         wr_force = wr_i && addr_i == A_FORCE;
  wire  [31:0] hit      = evt_i & sen_q & EVT_BITS;
  wire  [31:0] clr      = wr_stat  ? wdata_i : 32'd0;
  wire  [31:0] frc      = wr_force ? (wdata_i & EVT_BITS) : 32'd0;
  wire  [31:0] stat_d   = ((stat_q & ~clr) | hit | frc) & EVT_BITS;
  wire         summ     = |(stat_q & ERR_BITS);
  wire  [31:0] view     = stat_q | ({31'd0, summ} << SUM_POS);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stat_q <= '0;
      sen_q  <= '0;
      ien_q  <= '0;
      irq_q  <= 1'b0;
    end else begin
      stat_q <= stat_d;
      if (wr_i && addr_i == A_SEN) sen_q <= wdata_i & EVT_BITS;
      if (wr_i && addr_i == A_IEN) ien_q <= wdata_i & SIG_BITS;
      irq_q <= |(view & ien_q);
    end
  end

  always_comb begin
    case (addr_i)
      A_STAT:  rdata_o = view;
      A_SEN:   rdata_o = sen_q;
      A_IEN:   rdata_o = ien_q;
      default: rdata_o = 32'd0;
    endcase
  end

  assign irq_o = irq_q;

  assert_event_lands_R2: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((stat_q & $past(evt_i & sen_q & EVT_BITS)) == $past(evt_i & sen_q & EVT_BITS)));

  assert_no_stray_set_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_i |=> ((stat_q & ~$past(stat_q) & ~$past(sen_q)) == 32'd0));

  assert_idle_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_i && (evt_i & sen_q & EVT_BITS) == 32'd0) |=> $stable(stat_q));

  assert_clear_works_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stat && (evt_i & sen_q) == 32'd0) |=> ((stat_q & $past(wdata_i)) == 32'd0));

  assert_irq_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (ien_q == 32'd0) |=> !irq_o);

endmodule

// File: tb/irq_status_regs_test.sv
`timescale 1ns/1ps
module irq_status_regs_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] evt = '0;
  logic        wr = 1'b0;
  logic [1:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq;

  int total = 0;
  int bad = 0;
  bit done = 0;

  localparam logic [31:0] EVTM = 32'h017F_0173;
  localparam logic [31:0] ERRM = 32'h017F_0000;
  localparam logic [31:0] SIGM = EVTM | 32'h0000_8000;

  irq_status_regs uut (
    .clk(clk), .rst_n(rst_n), .evt_i(evt), .wr_i(wr), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq)
  );

  always #4 clk = ~clk;

  function automatic logic [31:0] view(input logic [31:0] s);
    return s | (((s & ERRM) != 0) ? 32'h8000 : 32'h0);
  endfunction

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic wreg(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk); wr = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr = 1'b0; wdata = '0;
  endtask

  task automatic rreg(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk); addr = a; #1 d = rdata;
  endtask

  task automatic pulse(input logic [31:0] e);
    @(negedge clk); evt = e;
    @(negedge clk); evt = '0;
  endtask

  initial begin
    #(8ns * 150000);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    rreg(2'd0, d); chk("R1 status", d, 32'd0);
    rreg(2'd1, d); chk("R1 sen", d, 32'd0);
    rreg(2'd2, d); chk("R1 ien", d, 32'd0);
    chk("R1 irq", {31'd0, irq}, 32'd0);

    pulse(32'hFFFF_FFFF);
    rreg(2'd0, d); chk("R3 all masked", d, 32'd0);

    for (int b = 0; b < 32; b++) begin
      logic [31:0] one, exp;
      one = 32'd1 << b;
      exp = view(one & EVTM);
      wreg(2'd1, one);
      rreg(2'd1, d); chk("R9 sen readback", d, one & EVTM);
      pulse(32'hFFFF_FFFF);
      rreg(2'd0, d); chk("R2 R3 R4 latch one bit", d, exp);
      wreg(2'd0, 32'd0);
      rreg(2'd0, d); chk("R5 write zero keeps", d, exp);
      wreg(2'd0, 32'hFFFF_FFFF);
      rreg(2'd0, d); chk("R5 clear all", d, 32'd0);
      wreg(2'd1, 32'd0);
      wreg(2'd3, one);
      rreg(2'd0, d); chk("R6 force", d, exp);
      rreg(2'd3, d); chk("R6 force reads zero", d, 32'd0);
      wreg(2'd2, one);
      rreg(2'd2, d); chk("R9 ien readback", d, one & SIGM);
      @(negedge clk);
      chk("R8 irq per bit", {31'd0, irq}, {31'd0, (exp & one & SIGM) != 0});
      wreg(2'd0, one);
      @(negedge clk);
      chk("R8 irq after clear", {31'd0, irq}, 32'd0);
      wreg(2'd2, 32'd0);
    end

    wreg(2'd3, 32'h0010_0000 | 32'h0000_8000);
    rreg(2'd0, d); chk("R4 summary via forced error", d, 32'h0010_8000);
    wreg(2'd2, 32'h0000_8000);
    @(negedge clk);
    chk("R4 R8 summary drives irq", {31'd0, irq}, 32'd1);
    wreg(2'd0, 32'h0000_8000);
    rreg(2'd0, d); chk("R4 summary not clearable", d, 32'h0010_8000);
    wreg(2'd0, 32'h0010_0000);
    rreg(2'd0, d); chk("R4 summary drops", d, 32'd0);
    @(negedge clk);
    chk("R8 irq drops", {31'd0, irq}, 32'd0);
    wreg(2'd2, 32'd0);

    wreg(2'd1, 32'hFFFF_FFFF);
    pulse(32'h0000_0003);
    @(negedge clk); evt = 32'h1; wr = 1'b1; addr = 2'd0; wdata = 32'h3;
    @(negedge clk); evt = '0; wr = 1'b0; wdata = '0;
    rreg(2'd0, d); chk("R7 event beats clear", d, 32'h1);

    @(negedge clk); evt = 32'h0100_0000;
    @(negedge clk); evt = '0;
    chk("R8 irq no sig enable", {31'd0, irq}, 32'd0);
    @(negedge clk); wr = 1'b1; addr = 2'd2; wdata = 32'h0100_0000;
    @(negedge clk); wr = 1'b0;
    chk("R8 irq one edge late", {31'd0, irq}, 32'd0);
    @(negedge clk);
    chk("R8 irq raised", {31'd0, irq}, 32'd1);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule